// File: doc/BRIEF.md
# Signed Integer Encoding Converter

This block re-encodes an integer word from one signed binary encoding into another. It understands four encodings: sign–magnitude, ones' complement, two's complement and excess (offset) binary. Each valid input carries its own source and destination selectors, so a stream of words can be re-encoded with a different pair on every cycle. The result is captured in a single output register, together with two flags.

Two corners need care. The symmetric encodings (sign–magnitude and ones' complement) each have a second, negative zero. The asymmetric encodings (two's complement and offset binary) reach one value further down, to −2^(W−1), than the symmetric ones can.

Every zero leaves the block in its single positive form, and a negative-zero flag reports that the input used the negative form. When the most negative asymmetric value is sent to a symmetric encoding, the output saturates to the nearest value the destination can hold, and an unrepresentable flag is raised. Internally every word passes through a sign plus (W)-bit magnitude form. A parameter chooses between two equivalent two's-complement negation circuits.

Top module: `snfc_conv`

## Requirements
- R1: Format codes are 0 = sign–magnitude (MSB is the sign, the lower W−1 bits the magnitude), 1 = ones' complement (a negative value is the bitwise inverse of its positive pattern), 2 = two's complement, and 3 = offset binary (the two's-complement pattern with its MSB inverted). Every value that both encodings can hold is converted exactly; for W=8, −43 is 10101011 in sign–magnitude, 11010100 in ones' complement, 11010101 in two's complement and 01010101 in offset binary.
- R2: out_valid is high in the cycle after a clock edge that sampled in_valid high, and low after one that sampled it low. out_data and the flags of that conversion are present in the same cycle.
- R3: A synchronous active-high reset clears out_valid, out_data, out_negzero and out_unrep to 0.
- R4: A clock edge with in_valid low leaves out_data, out_negzero and out_unrep unchanged.
- R5: out_negzero is 1 exactly when the converted input was a negative zero: 1 followed by W−1 zeros in sign–magnitude, or all ones in ones' complement.
- R6: A zero result is always written as positive zero: all zeros for codes 0, 1 and 2, and 1 followed by W−1 zeros for code 3.
- R7: Converting −2^(W−1) (two's complement 100..0, offset binary 000..0) to code 0 or code 1 sets out_unrep. The output saturates to −(2^(W−1)−1): all ones in sign–magnitude, and 1 followed by W−1 zeros in ones' complement.
- R8: out_unrep is 0 for every other conversion, including every conversion into codes 2 and 3.
- R9: A conversion whose source and destination codes are equal returns the input unchanged, except that a negative zero becomes positive zero.
- R10: The parameter NEG_SCAN selects the negation circuit: 0 inverts and adds one, 1 keeps every bit up to and including the lowest 1 and inverts the bits above it. Both give identical outputs for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word and selectors are valid |
| in_data | input | WIDTH | Word in the source encoding |
| in_src | input | 2 | Source encoding code |
| in_dst | input | 2 | Destination encoding code |
| out_valid | output | 1 | Registered result is valid |
| out_data | output | WIDTH | Word in the destination encoding |
| out_negzero | output | 1 | Input was a negative zero |
| out_unrep | output | 1 | Value saturated because the destination cannot hold it |

## Verification
The bench builds two copies at WIDTH=8, one with NEG_SCAN=0 and one with NEG_SCAN=1, and feeds both the same stimulus. Eight bits keep the full space of 256 words × 16 code pairs small enough to sweep exhaustively. That sweep puts both negative zeros, the −128 saturation and every same-code round trip into the stream, with idle cycles in between. Comparing the two copies cycle by cycle shows that the two negation circuits agree on every word, including 10000000, which negates to itself.

// File: rtl/snfc_pkg.sv
`timescale 1ns/1ps
package snfc_pkg;

   typedef enum logic [1:0] {
      FMT_SIGNMAG = 2'd0,
      FMT_ONES    = 2'd1,
      FMT_TWOS    = 2'd2,
      FMT_EXCESS  = 2'd3
   } fmt_e;

   // Canonical intermediate: sign plus full-width magnitude
   // (the magnitude of -2^(W-1) needs all W bits).
   function automatic logic is_symmetric(input fmt_e f);
      return (f == FMT_SIGNMAG) || (f == FMT_ONES);
   endfunction

endpackage

// File: rtl/snfc_negate.sv
`timescale 1ns/1ps
// Two's-complement negation, variant chosen by parameter.
module snfc_negate #(
   parameter int WIDTH    = 8,
   parameter bit NEG_SCAN = 1'b0
) (
   input  logic [WIDTH-1:0] x,
   output logic [WIDTH-1:0] y
);

   localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

   generate
      if (NEG_SCAN) begin : g_scan
         // Keep bits through the lowest set bit, invert everything above.
         always_comb begin
            logic seen;
            seen = 1'b0;
            for (int i = 0; i < WIDTH; i++) begin
               y[i] = seen ? ~x[i] : x[i];
               seen = seen | x[i];
            end
         end
      end else begin : g_add
         assign y = ~x + ONE;
      end
   endgenerate

endmodule

// File: rtl/snfc_decode.sv
`timescale 1ns/1ps
// Any source encoding -> (sign, magnitude, negative-zero).
module snfc_decode
   import snfc_pkg::*;
#(
   parameter int WIDTH    = 8,
   parameter bit NEG_SCAN = 1'b0
) (
   input  logic [WIDTH-1:0] word,
   input  fmt_e             src,
   output logic             sign,
   output logic [WIDTH-1:0] mag,
   output logic             negzero
);

   localparam int MW = WIDTH - 1;

   logic [WIDTH-1:0] twos_word;
   logic [WIDTH-1:0] twos_neg;
   logic             raw_sign;
   logic [WIDTH-1:0] raw_mag;

   // Offset binary maps onto two's complement by flipping the MSB.
   assign twos_word = (src == FMT_EXCESS) ? {~word[WIDTH-1], word[MW-1:0]} : word;

   snfc_negate #(.WIDTH(WIDTH), .NEG_SCAN(NEG_SCAN)) u_neg (
      .x (twos_word),
      .y (twos_neg)
   );

   always_comb begin
      raw_sign = word[WIDTH-1];
      raw_mag  = {1'b0, word[MW-1:0]};
      unique case (src)
         FMT_SIGNMAG: begin
            raw_sign = word[WIDTH-1];
            raw_mag  = {1'b0, word[MW-1:0]};
         end
         FMT_ONES: begin
            raw_sign = word[WIDTH-1];
            raw_mag  = {1'b0, word[WIDTH-1] ? ~word[MW-1:0] : word[MW-1:0]};
         end
         FMT_TWOS, FMT_EXCESS: begin
            raw_sign = twos_word[WIDTH-1];
            raw_mag  = twos_word[WIDTH-1] ? twos_neg : twos_word;
         end
         default: begin
            raw_sign = 1'b0;
            raw_mag  = '0;
         end
      endcase
   end

   // Only the symmetric sources can produce a signed zero.
   assign negzero = raw_sign && (raw_mag == '0);
   assign sign    = raw_sign && (raw_mag != '0);
   assign mag     = raw_mag;

endmodule

// File: rtl/snfc_encode.sv
`timescale 1ns/1ps
// (sign, magnitude) -> destination encoding, with saturation.
module snfc_encode
   import snfc_pkg::*;
#(
   parameter int WIDTH    = 8,
   parameter bit NEG_SCAN = 1'b0
) (
   input  logic             sign,
   input  logic [WIDTH-1:0] mag,
   input  fmt_e             dst,
   output logic [WIDTH-1:0] word,
   output logic             unrep
);

   localparam int               MW      = WIDTH - 1;
   localparam logic [WIDTH-1:0] MIN_MAG = {1'b1, {MW{1'b0}}};
   localparam logic [WIDTH-1:0] MAX_SYM = {1'b0, {MW{1'b1}}};

   logic             too_big;
   logic [WIDTH-1:0] sym_mag;
   logic [WIDTH-1:0] mag_neg;
   logic [WIDTH-1:0] twos_word;

   snfc_negate #(.WIDTH(WIDTH), .NEG_SCAN(NEG_SCAN)) u_neg (
      .x (mag),
      .y (mag_neg)
   );

   assign too_big   = sign && (mag == MIN_MAG);
   assign unrep     = too_big && is_symmetric(dst);
   assign sym_mag   = too_big ? MAX_SYM : mag;
   assign twos_word = sign ? mag_neg : mag;

   always_comb begin
      unique case (dst)
         FMT_SIGNMAG: word = {sign, sym_mag[MW-1:0]};
         FMT_ONES:    word = {sign, sign ? ~sym_mag[MW-1:0] : sym_mag[MW-1:0]};
         FMT_TWOS:    word = twos_word;
         FMT_EXCESS:  word = {~twos_word[WIDTH-1], twos_word[MW-1:0]};
         default:     word = '0;
      endcase
   end

endmodule

// File: rtl/snfc_conv.sv
`timescale 1ns/1ps
// Signed integer encoding converter: decode, encode, one output register.
module snfc_conv
   import snfc_pkg::*;
#(
   parameter int WIDTH    = 8,
   parameter bit NEG_SCAN = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [WIDTH-1:0] in_data,
   input  logic [1:0]       in_src,
   input  logic [1:0]       in_dst,
   output logic             out_valid,
   output logic [WIDTH-1:0] out_data,
   output logic             out_negzero,
   output logic             out_unrep
);

   generate
      if (WIDTH < 2) begin : g_width_bad
         $error("snfc_conv: WIDTH must be at least 2");
      end
   endgenerate

   fmt_e             src_f;
   fmt_e             dst_f;
   logic             mid_sign;
   logic [WIDTH-1:0] mid_mag;
   logic             mid_negzero;
   logic [WIDTH-1:0] enc_word;
   logic             enc_unrep;

   assign src_f = fmt_e'(in_src);
   assign dst_f = fmt_e'(in_dst);

   snfc_decode #(.WIDTH(WIDTH), .NEG_SCAN(NEG_SCAN)) u_dec (
      .word    (in_data),
      .src     (src_f),
      .sign    (mid_sign),
      .mag     (mid_mag),
      .negzero (mid_negzero)
   );

   snfc_encode #(.WIDTH(WIDTH), .NEG_SCAN(NEG_SCAN)) u_enc (
      .sign  (mid_sign),
      .mag   (mid_mag),
      .dst   (dst_f),
      .word  (enc_word),
      .unrep (enc_unrep)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid   <= 1'b0;
         out_data    <= '0;
         out_negzero <= 1'b0;
         out_unrep   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_data    <= enc_word;
            out_negzero <= mid_negzero;
            out_unrep   <= enc_unrep;
         end
      end
   end

endmodule

// File: rtl/snfc_conv_chk.sv
`timescale 1ns/1ps
module snfc_conv_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic [WIDTH-1:0] in_data,
   input logic [1:0]       in_src,
   input logic [1:0]       in_dst,
   input logic             out_valid,
   input logic [WIDTH-1:0] out_data,
   input logic             out_negzero,
   input logic             out_unrep
);

   localparam logic [WIDTH-1:0] TOP_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

   // R2
   valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   // R2
   idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   // R4
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(out_data) && $stable(out_negzero) && $stable(out_unrep)));

   // R5
   negzero_ones_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_src == 2'd1 && in_data == {WIDTH{1'b1}}) |=> out_negzero);

   // R6
   zero_excess_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_src == 2'd0 && in_data == TOP_ONLY && in_dst == 2'd3)
      |=> (out_data == TOP_ONLY));

   // R7
   sat_signmag_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_src == 2'd2 && in_data == TOP_ONLY && in_dst == 2'd0)
      |=> (out_unrep && out_data == {WIDTH{1'b1}}));

   // R8
   no_unrep_asym_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_dst[1]) |=> !out_unrep);

   // R9
   same_twos_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_src == 2'd2 && in_dst == 2'd2)
      |=> (out_data == $past(in_data) && !out_negzero && !out_unrep));

endmodule

bind snfc_conv snfc_conv_chk #(.WIDTH(WIDTH)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .in_valid    (in_valid),
   .in_data     (in_data),
   .in_src      (in_src),
   .in_dst      (in_dst),
   .out_valid   (out_valid),
   .out_data    (out_data),
   .out_negzero (out_negzero),
   .out_unrep   (out_unrep)
);

// File: tb/snfc_conv_bench.sv
`timescale 1ns/1ps
module snfc_conv_bench;

   localparam int W = 8;

   typedef struct {
      logic [W-1:0] data;
      logic         nz;
      logic         ur;
      string        tag;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic [W-1:0] in_data = '0;
   logic [1:0]   in_src = '0;
   logic [1:0]   in_dst = '0;
   logic         out_valid, out_valid_s;
   logic [W-1:0] out_data, out_data_s;
   logic         out_negzero, out_negzero_s;
   logic         out_unrep, out_unrep_s;

   int   n_cmp = 0;
   int   n_bad = 0;
   bit   mon_on = 1'b0;
   bit   done = 1'b0;
   exp_t sb[$];
   exp_t last_exp;

   always #4 clk = ~clk;

   snfc_conv #(.WIDTH(W), .NEG_SCAN(1'b0)) u_snfc_conv (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .in_src(in_src), .in_dst(in_dst), .out_valid(out_valid),
      .out_data(out_data), .out_negzero(out_negzero), .out_unrep(out_unrep));

   snfc_conv #(.WIDTH(W), .NEG_SCAN(1'b1)) u_snfc_conv_scan (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .in_src(in_src), .in_dst(in_dst), .out_valid(out_valid_s),
      .out_data(out_data_s), .out_negzero(out_negzero_s), .out_unrep(out_unrep_s));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Reference model written from the requirement text, by integer value.
   function automatic exp_t model(input int d, input int s, input int t);
      exp_t e;
      int   v;
      int   od;
      e.nz = 1'b0;
      e.ur = 1'b0;
      v = 0;
      case (s)
         0: begin v = d & 127; if (d & 128) begin v = -v; e.nz = (v == 0); end end
         1: begin
            if (d & 128) begin v = -((~d) & 127); e.nz = (v == 0); end
            else v = d;
         end
         2: v = (d & 128) ? d - 256 : d;
         default: v = d - 128;
      endcase
      if (t < 2 && v == -128) begin e.ur = 1'b1; v = -127; end
      case (t)
         0: od = (v < 0) ? (128 | -v) : v;
         1: od = (v < 0) ? ((~(-v)) & 255) : v;
         2: od = v & 255;
         default: od = (v + 128) & 255;
      endcase
      e.data = od[W-1:0];
      if (e.ur) e.tag = "R7";
      else if (e.nz) e.tag = "R5";
      else if (v == 0) e.tag = "R6";
      else if (s == t) e.tag = "R9";
      else e.tag = "R1";
      return e;
   endfunction

   task automatic drive(input int d, input int s, input int t);
      exp_t e;
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = d[W-1:0];
      in_src   = s[1:0];
      in_dst   = t[1:0];
      e = model(d, s, t);
      sb.push_back(e);
      last_exp = e;
   endtask

   task automatic idle(input int d);
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = d[W-1:0];
      in_src   = d[1:0];
      in_dst   = d[3:2];
   endtask

   // Monitor: pops one expected item per valid result.
   initial begin
      forever begin
         @(negedge clk);
         if (mon_on && !rst) begin
            // R10: both negation variants must agree on every cycle
            check(out_valid_s == out_valid && out_data_s == out_data &&
                  out_negzero_s == out_negzero && out_unrep_s == out_unrep,
                  "R10", out_data_s, out_data);
            if (out_valid) begin
               if (sb.size() == 0) begin
                  check(1'b0, "R2 unexpected out_valid", 1, 0);
               end else begin
                  exp_t e;
                  e = sb.pop_front();
                  check(out_data == e.data, e.tag, out_data, e.data);
                  check(out_negzero == e.nz, "R5 negzero flag", out_negzero, e.nz);
                  check(out_unrep == e.ur, e.ur ? "R7 unrep flag" : "R8 unrep flag",
                        out_unrep, e.ur);
               end
            end else begin
               check(sb.size() == 0, "R2 result missing", sb.size(), 0);
            end
         end
      end
   end

   // Watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int cnt;
      repeat (3) @(negedge clk);
      // R3: reset state
      check(out_valid == 1'b0 && out_data == '0 && !out_negzero && !out_unrep,
            "R3 reset state", {out_valid, out_data}, 0);
      @(negedge clk);
      rst = 1'b0;
      mon_on = 1'b1;

      // Directed corners: -43 in every encoding (R1), -128 saturation (R7)
      drive(8'hAB, 0, 1);
      drive(8'hAB, 0, 2);
      drive(8'hAB, 0, 3);
      drive(8'h80, 2, 0);
      drive(8'h00, 3, 1);
      drive(8'hFF, 1, 2);
      drive(8'h80, 0, 3);
      idle(8'h5A);

      // Exhaustive sweep with idle gaps
      cnt = 0;
      for (int s = 0; s < 4; s++) begin
         for (int t = 0; t < 4; t++) begin
            for (int d = 0; d < 256; d++) begin
               drive(d, s, t);
               cnt++;
               if (cnt % 7 == 0) idle(d ^ 8'h3C);
            end
         end
      end

      // R4: idle cycles with changing inputs leave the result unchanged
      drive(8'h80, 2, 1);
      for (int i = 0; i < 4; i++) begin
         idle(i * 37 + 5);
      end
      @(negedge clk);
      check(out_data == last_exp.data && out_unrep == last_exp.ur &&
            out_negzero == last_exp.nz, "R4 hold", out_data, last_exp.data);
      check(out_valid == 1'b0, "R2 idle valid", out_valid, 0);

      // R3: synchronous reset while input is valid
      mon_on = 1'b0;
      @(negedge clk);
      rst      = 1'b1;
      in_valid = 1'b1;
      in_data  = 8'hAB;
      @(negedge clk);
      check(out_valid == 1'b0 && out_data == '0 && !out_unrep && !out_negzero,
            "R3 reset clears", {out_valid, out_data}, 0);
      in_valid = 1'b0;
      check(sb.size() == 0, "R2 leftover items", sb.size(), 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule